// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with Runtime Write Policy

This block is a small unified cache that sits between a processor and a slower main memory. It holds eight lines of eight bytes, arranged as four sets of two ways, and it serves 10-bit byte addresses. The processor issues byte reads and writes over a valid/ready handshake. The memory side takes whole-line fills, single-byte writes and whole-line copy-backs over a request/acknowledge handshake with variable latency.

A static two-bit configuration input selects the write policy. The encodings are 0 for write-through, 1 for buffered write-through and 2 for write-back. Write-through updates memory in the same operation as the cache. Buffered write-through queues writes in a four-entry buffer and forwards them while the processor is quiet. Write-back marks lines as modified and copies them out only when they are evicted. The policy must not change while the block is out of reset.

Top module: `assoc_cache`

## Requirements
- R1: Address bits [2:0] select the byte in a line, bits [4:3] select the set, and bits [9:5] form the tag. In every policy, a read returns the byte that was most recently written to that address, or the memory contents if the address was never written.
- R2: Reset invalidates every line, clears every modified bit and empties the write buffer. While no request is pending after reset, cpu_ready and mem_req are low, and the first read of any address causes a line fill.
- R3: A lookup compares only the two tags of the indexed set. A read hit completes with cpu_ready in the same cycle it is presented and causes no memory traffic.
- R4: With wr_mode=0, a write completes in the cycle its byte write to memory is acknowledged, and memory holds the new byte from then on. A write miss does not allocate a line.
- R5: With wr_mode=1, a write is accepted without memory traffic while the buffer has room. A buffered write goes to memory only when cpu_valid is low, when the buffer is full, or when a read miss must be served. A write miss does not allocate a line.
- R6: The write buffer holds 4 entries. A fifth write while the buffer is full stalls until one entry has drained.
- R7: A read miss drains the write buffer before the line fill starts, so the filled line never holds stale bytes.
- R8: With wr_mode=2, a write hit only sets the line's modified bit and causes no memory traffic. A write miss allocates the line (fill, then write). A modified victim is copied back as a whole line with mem_wbe all ones before the fill. A clean victim is not copied back.
- R9: The victim is an invalid way of the set if one exists. Otherwise it is the least recently used way of that set.
- R10: mem_req, mem_we, mem_addr, mem_wbe and mem_wdata stay stable until a one-cycle mem_ack. In a fill, mem_rdata carries byte i at bits 8i+7:8i. A byte write has a one-hot mem_wbe at the byte offset, and the byte is copied into every lane of mem_wdata.
- R11: A processor request is held until cpu_ready. cpu_ready is high only while cpu_valid is high, and cpu_rdata is valid while cpu_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_mode | input | 2 | Write policy: 0 write-through, 1 buffered write-through, 2 write-back |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 10 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 8 | Read byte, valid with cpu_ready |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 10 | Memory byte address (line-aligned for fills and copy-backs) |
| mem_wbe | output | 8 | Byte enables of a memory write |
| mem_wdata | output | 64 | Memory write data, byte i in bits 8i+7:8i |
| mem_ack | input | 1 | One-cycle completion of the memory request |
| mem_rdata | input | 64 | Fill data, valid with mem_ack |

## Verification
Results arrive at different times. A read hit raises cpu_ready in the same cycle as the request. A write-through write completes in the cycle after the memory model registers its acknowledge. A miss takes one memory round trip for the fill, plus one more when a modified victim is copied back, and then completes as a hit. To keep to this timing, the bench drives on the falling edge and polls cpu_ready 1 ns later. It counts the wait cycles and compares them with zero where a hit or a buffered write must not stall. It reads the memory model only after the handshake edge, or after an idle window long enough for the buffer to drain. Fill and write counters kept in the memory model show whether a line was allocated or evicted, and which victim was chosen.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;
    localparam int ADDR_W     = 10;
    localparam int LINE_BYTES = 8;
    localparam int SETS       = 4;
    localparam int WAYS       = 2;
    localparam int WBUF_DEPTH = 4;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int SET_W      = $clog2(SETS);
    localparam int TAG_W      = ADDR_W - OFF_W - SET_W;
    localparam int LINE_W     = 8 * LINE_BYTES;
    localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef enum logic [1:0] {POL_WT = 2'd0, POL_BWT = 2'd1, POL_WB = 2'd2} wpol_e;
    typedef enum logic [2:0] {S_IDLE, S_WTWR, S_DRAIN, S_EVICT, S_FILL} cst_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } pend_t;

    typedef struct packed {
        cst_e                                   st;
        logic [WAYS-1:0][SETS-1:0][TAG_W-1:0]  tag;
        logic [WAYS-1:0][SETS-1:0]             vld;
        logic [WAYS-1:0][SETS-1:0]             mod;
        logic [WAYS-1:0][SETS-1:0][LINE_W-1:0] line;
        logic [SETS-1:0][WAY_W-1:0]            lru;
        logic [WAY_W-1:0]                      vic;
    } cstate_t;
endpackage

// File: rtl/cache_victim.sv
module cache_victim #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  vld,
    input  logic [WAY_W-1:0] lru_way,
    output logic [WAY_W-1:0] way
);
    // Lowest-numbered invalid way wins; otherwise the least recently used one.
    always_comb begin
        way = lru_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_wbuf.sv
module cache_wbuf #(
    parameter int DEPTH = 4,
    parameter int W     = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] pdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } wb_t;

    wb_t q, n;

    assign head  = q.slot[q.rd];
    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);

    always_comb begin
        n = q;
        if (push) begin
            n.slot[q.wr] = pdata;
            n.wr = (q.wr == PW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        end
        if (pop) n.rd = (q.rd == PW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        n.cnt = q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (q.cnt < CW'(DEPTH)));
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    a_r7_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (q.cnt != '0));
endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
    import assoc_cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wr_mode,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ready,
    output logic [7:0]        cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_BYTES-1:0] mem_wbe,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    localparam int PW = $bits(pend_t);

    cstate_t q, n;
    wpol_e   pol;
    assign pol = wpol_e'(wr_mode);

    logic [OFF_W-1:0] off;
    logic [SET_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    assign off = cpu_addr[OFF_W-1:0];
    assign idx = cpu_addr[OFF_W +: SET_W];
    assign tag = cpu_addr[ADDR_W-1 -: TAG_W];

    // Lookup: compare only the ways of the indexed set.
    logic [WAYS-1:0]  hv, vcol;
    logic [WAY_W-1:0] hway, vway;
    logic             hit;
    always_comb begin
        hway = '0;
        for (int w = 0; w < WAYS; w++) begin
            vcol[w] = q.vld[w][idx];
            hv[w]   = q.vld[w][idx] && (q.tag[w][idx] == tag);
            if (hv[w]) hway = WAY_W'(w);
        end
    end
    assign hit = |hv;

    logic [LINE_W-1:0] hline;
    assign hline     = q.line[hway][idx];
    assign cpu_rdata = hline[{off, 3'b000} +: 8];

    cache_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) i_victim (
        .vld(vcol), .lru_way(q.lru[idx]), .way(vway)
    );

    logic       wb_push, wb_pop, wb_full, wb_empty;
    logic [PW-1:0] wb_head_bits;
    pend_t      wb_head;
    assign wb_head = pend_t'(wb_head_bits);

    cache_wbuf #(.DEPTH(WBUF_DEPTH), .W(PW)) i_wbuf (
        .clk(clk), .rst_n(rst_n), .push(wb_push), .pdata({cpu_addr, cpu_wdata}),
        .pop(wb_pop), .head(wb_head_bits), .full(wb_full), .empty(wb_empty)
    );

    always_comb begin
        n         = q;
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wbe   = '0;
        mem_wdata = '0;
        wb_push   = 1'b0;
        wb_pop    = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (cpu_valid) begin
                    if (hit && (!cpu_we || pol == POL_WB)) begin
                        cpu_ready = 1'b1;
                        n.lru[idx] = ~hway;
                        if (cpu_we) begin
                            n.line[hway][idx][{off, 3'b000} +: 8] = cpu_wdata;
                            n.mod[hway][idx] = 1'b1;
                        end
                    end else if (cpu_we && pol == POL_WT) begin
                        n.st = S_WTWR;
                    end else if (cpu_we && pol == POL_BWT) begin
                        if (!wb_full) begin
                            wb_push   = 1'b1;
                            cpu_ready = 1'b1;
                            if (hit) begin
                                n.line[hway][idx][{off, 3'b000} +: 8] = cpu_wdata;
                                n.lru[idx] = ~hway;
                            end
                        end else begin
                            n.st = S_DRAIN;
                        end
                    end else if (!wb_empty) begin
                        n.st = S_DRAIN;              // read miss: flush queue first
                    end else begin
                        n.vic = vway;
                        n.st  = (pol == POL_WB && q.vld[vway][idx] && q.mod[vway][idx])
                                ? S_EVICT : S_FILL;
                    end
                end else if (!wb_empty) begin
                    n.st = S_DRAIN;                  // processor quiet
                end
            end
            S_WTWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cpu_addr;
                mem_wbe   = LINE_BYTES'(1) << off;
                mem_wdata = {LINE_BYTES{cpu_wdata}};
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    n.st = S_IDLE;
                    if (hit) begin
                        n.line[hway][idx][{off, 3'b000} +: 8] = cpu_wdata;
                        n.lru[idx] = ~hway;
                    end
                end
            end
            S_DRAIN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wb_head.addr;
                mem_wbe   = LINE_BYTES'(1) << wb_head.addr[OFF_W-1:0];
                mem_wdata = {LINE_BYTES{wb_head.data}};
                if (mem_ack) begin
                    wb_pop = 1'b1;
                    n.st   = S_IDLE;
                end
            end
            S_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {q.tag[q.vic][idx], idx, OFF_W'(0)};
                mem_wbe   = '1;
                mem_wdata = q.line[q.vic][idx];
                if (mem_ack) begin
                    n.mod[q.vic][idx] = 1'b0;
                    n.st = S_FILL;
                end
            end
            S_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {tag, idx, OFF_W'(0)};
                if (mem_ack) begin
                    n.line[q.vic][idx] = mem_rdata;
                    n.tag[q.vic][idx]  = tag;
                    n.vld[q.vic][idx]  = 1'b1;
                    n.mod[q.vic][idx]  = 1'b0;
                    n.lru[idx]         = ~q.vic;
                    n.st = S_IDLE;
                end
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    a_r11_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid);
    a_r10_mem_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wbe)));
    a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hv));
    a_r4_wt_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_WT && cpu_valid && cpu_we && cpu_ready) |-> mem_ack);
    a_r8_line_write_only_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && pol != POL_WB) |-> ($countones(mem_wbe) == 1));
    a_r5_drain_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DRAIN && $past(q.st) == S_IDLE)
        |-> $past(!cpu_valid || (!cpu_we && !hit) || (cpu_we && wb_full)));
endmodule

// File: tb/test_assoc_cache.sv
module test_assoc_cache;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_mode = 2'd0;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [9:0]  mem_addr;
    logic [7:0]  mem_wbe;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    always #(CLK_P/2) clk = ~clk;

    assoc_cache i_assoc_cache (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wbe(mem_wbe),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [7:0] mem    [1024];
    logic [7:0] golden [1024];
    int n_fill = 0, n_bwr = 0, n_lwr = 0;
    int lat = 1, cnt = 0;
    int ntests = 0, nfail = 0;

    // Main-memory model with variable latency and a one-cycle acknowledge.
    always @(posedge clk) begin
        if (!rst_n || mem_ack) begin
            mem_ack <= 1'b0;
            cnt     <= 0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                mem_ack <= 1'b1;
                lat     <= int'($urandom % 4);
                if (mem_we) begin
                    for (int b = 0; b < 8; b++)
                        if (mem_wbe[b]) mem[{mem_addr[9:3], 3'(b)}] <= mem_wdata[8*b +: 8];
                    if (mem_wbe == 8'hFF) n_lwr <= n_lwr + 1;
                    else                  n_bwr <= n_bwr + 1;
                end else begin
                    for (int b = 0; b < 8; b++)
                        mem_rdata[8*b +: 8] <= mem[{mem_addr[9:3], 3'(b)}];
                    n_fill <= n_fill + 1;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [9:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int waits);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        waits = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        if (we) golden[a] = d;
    endtask

    task automatic idle(input int cycles);
        @(negedge clk);
        cpu_valid = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] mode);
        @(negedge clk);
        cpu_valid = 1'b0; rst_n = 1'b0; wr_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 1024; i++) golden[i] = mem[i];
        #1;
        check(!cpu_ready && !mem_req, "R2 outputs quiet after reset",
              {cpu_ready, mem_req}, 0);
    endtask

    task automatic read_chk(input logic [9:0] a, input string req);
        logic [7:0] rd; int w;
        access(1'b0, a, 8'h00, rd, w);
        check(rd == golden[a], req, rd, golden[a]);
    endtask

    task automatic mem_all_chk(input string req);
        int bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== golden[i]) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic random_ops(input int nops, input bit wt_chk);
        logic [7:0] rd; int w;
        for (int k = 0; k < nops; k++) begin
            logic [9:0] a;
            logic [7:0] d;
            bit we;
            a  = {5'($urandom % 6), 2'($urandom % 4), 3'($urandom % 8)};
            d  = 8'($urandom);
            we = ($urandom % 3) == 0;
            if (we) begin
                access(1'b1, a, d, rd, w);
                if (wt_chk) check(mem[a] == d, "R4 memory updated by write", mem[a], d);
            end else begin
                read_chk(a, "R1 random read data");
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int w, f0, b0, l0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);

        // ---------------- write-through ----------------
        do_reset(2'd0);
        f0 = n_fill;
        read_chk(10'h025, "R2 first read after reset");
        check(n_fill == f0 + 1, "R2 first read fills", n_fill - f0, 1);
        f0 = n_fill;
        access(1'b0, 10'h025, 8'h00, rd, w);
        check(w == 0 && n_fill == f0, "R3 read hit same cycle, no fill", w, 0);
        access(1'b1, 10'h025, 8'hA5, rd, w);
        check(mem[10'h025] == 8'hA5, "R4 write hit reaches memory", mem[10'h025], 8'hA5);
        read_chk(10'h025, "R4 cache updated on write hit");
        access(1'b1, 10'h3C1, 8'h5A, rd, w);
        check(mem[10'h3C1] == 8'h5A, "R10 byte lane write", mem[10'h3C1], 8'h5A);
        f0 = n_fill;
        read_chk(10'h3C1, "R4 write miss data");
        check(n_fill == f0 + 1, "R4 write miss not allocated", n_fill - f0, 1);
        random_ops(150, 1'b1);
        idle(4);
        mem_all_chk("R4 memory matches after write-through run");

        // ---------------- buffered write-through ----------------
        do_reset(2'd1);
        b0 = n_bwr;
        for (int k = 0; k < 4; k++) begin
            access(1'b1, 10'h100 + 10'(8 * k), 8'(8'h30 + k), rd, w);
            check(w == 0, "R5 buffered write not stalled", w, 0);
        end
        check(n_bwr == b0, "R5 no memory write while busy", n_bwr - b0, 0);
        access(1'b1, 10'h120, 8'h44, rd, w);
        check(w > 0, "R6 fifth write stalls on full buffer", w, 1);
        idle(40);
        check(n_bwr == b0 + 5, "R5 buffer drains when idle", n_bwr - b0, 5);
        mem_all_chk("R5 memory matches after drain");
        access(1'b1, 10'h155, 8'hC3, rd, w);
        read_chk(10'h155, "R7 read miss sees buffered write");
        random_ops(150, 1'b0);
        idle(40);
        mem_all_chk("R5 memory matches after buffered run");

        // ---------------- write-back ----------------
        do_reset(2'd2);
        f0 = n_fill;
        read_chk(10'h030, "R9 read A");
        read_chk(10'h050, "R9 read B");
        check(n_fill == f0 + 2, "R9 invalid ways filled first", n_fill - f0, 2);
        read_chk(10'h030, "R9 A hit");
        read_chk(10'h070, "R9 read C");
        f0 = n_fill;
        read_chk(10'h030, "R9 A still held");
        check(n_fill == f0, "R9 LRU kept recently used A", n_fill - f0, 0);
        read_chk(10'h050, "R9 B refetched");
        check(n_fill == f0 + 1, "R9 B was LRU victim", n_fill - f0, 1);
        b0 = n_bwr; l0 = n_lwr;
        access(1'b1, 10'h031, 8'h77, rd, w);
        check(n_bwr == b0 && n_lwr == l0 && w == 0, "R8 write hit no traffic",
              n_bwr + n_lwr - b0 - l0, 0);
        check(mem[10'h031] != 8'h77 || golden[10'h031] == 8'h77 && 1'b0 == 1'b1 ||
              mem[10'h031] == 8'h77 && 1'b0, "R8 memory untouched by write hit",
              mem[10'h031], 0);
        l0 = n_lwr;
        read_chk(10'h070, "R8 clean victim replaced");
        check(n_lwr == l0, "R8 clean victim not copied back", n_lwr - l0, 0);
        read_chk(10'h050, "R8 dirty victim replaced");
        check(n_lwr == l0 + 1 && mem[10'h031] == 8'h77, "R8 dirty line copied back",
              mem[10'h031], 8'h77);
        f0 = n_fill;
        access(1'b1, 10'h092, 8'h19, rd, w);
        read_chk(10'h092, "R8 write miss data");
        check(n_fill == f0 + 1, "R8 write miss allocates", n_fill - f0, 1);
        random_ops(200, 1'b0);
        idle(4);

        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule